// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block sits beside a small 8-bit processor core and decides which of seven request sources is handed to the core next. Four sources are active-low external pins and three are internal peripheral flags: two timer overflow flags and one serial-port flag. Each external pin is synchronized and then detected either on a falling edge, which is latched in a pending flag, or as a low level, which is passed through unlatched. Pending requests are masked by per-source enables and a global enable. They are then resolved in two priority levels, with a fixed polling order inside each level.

The winning request is shown to the core as a request strobe and a 16-bit vector address. The core answers with an acknowledge strobe when it vectors and with a return strobe when the handler ends. The block tracks which priority levels are in service, so a low-priority handler can be preempted only by a high-priority request and a high-priority handler cannot be preempted at all. The two added external sources are configured through an 8-bit control register. Each of its bits can be written on its own through a bit address or all at once through a byte address. The enable and priority bits of the first five sources, the trigger mode of the first two pins and the peripheral flags come in as plain inputs.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `irqReq` is 0, `timerClr` is 0 and `ctrlRdData` reads 0x00.
- R2: A byte write at address 0xC0 loads the control register. A bit write at bit address 0xC0+n (n = 0..7) sets or clears only bit n. Byte writes to other addresses and bit writes outside 0xC0..0xC7 change nothing. Layout from bit 7 down to bit 0: ext3 high priority, ext3 enable, ext3 pending, ext3 edge mode, ext2 high priority, ext2 enable, ext2 pending, ext2 edge mode.
- R3: In edge mode (mode bit 1), a falling edge on the synchronized pin sets a pending flag. The flag stays set after the pin returns high and is cleared when that source is acknowledged. For ext2 and ext3 the flag reads back at bits 1 and 5.
- R4: In level mode (mode bit 0), a source is pending exactly while its synchronized pin is low. The request drops when the pin returns high, with no acknowledge.
- R5: Vector addresses are 0x0003 ext0, 0x000B timer0, 0x0013 ext1, 0x001B timer1, 0x0023 serial, 0x0033 ext2, 0x003B ext3.
- R6: Among eligible sources of one priority level, the first in the order ext0, timer0, ext1, timer1, serial, ext2, ext3 is presented.
- R7: An eligible high-priority source is presented ahead of every low-priority source, regardless of polling order.
- R8: A source is eligible only when pending and individually enabled (`srcEn` bits 0..4 in polling order; control-register enables for ext2/ext3). Nothing is requested while `globalEn` is 0.
- R9: An acknowledge marks the presented level in service. While low is in service only high-priority sources are presented. While high is in service nothing is presented. A return strobe ends service of the high level if it is active, otherwise of the low level.
- R10: Acknowledging timer0 or timer1 pulses `timerClr` bit 0 or bit 1 in the acknowledge cycle. Acknowledging the serial source pulses neither bit, so its flag persists.
- R11: An acknowledge while `irqReq` is 0 has no effect on pending flags or service state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extPinN | input | 4 | Active-low external request pins, ext0..ext3 |
| extEdgeMode | input | 2 | Edge (1) or level (0) mode for ext0, ext1 |
| tmrFlag | input | 2 | Timer0/timer1 overflow flags |
| serFlag | input | 1 | Serial port request flag |
| srcEn | input | 5 | Enables for ext0, timer0, ext1, timer1, serial |
| srcHiPrio | input | 5 | High-priority bits, same order as `srcEn` |
| globalEn | input | 1 | Global interrupt enable |
| byteWrEn | input | 1 | Byte write strobe |
| byteAddr | input | 8 | Byte write address |
| byteData | input | 8 | Byte write data |
| bitWrEn | input | 1 | Bit write strobe |
| bitAddr | input | 8 | Bit address |
| bitData | input | 1 | Bit value to write |
| ctrlRdData | output | 8 | Control register readback with live pending bits |
| irqAck | input | 1 | Core acknowledge (vectoring) strobe |
| irqRet | input | 1 | Return-from-interrupt strobe |
| irqReq | output | 1 | Interrupt request to the core |
| irqVector | output | 16 | Vector address of the presented source |
| timerClr | output | 2 | Clear pulses for timer0/timer1 flags |

## Verification
The bench builds the block with its default parameters: a two-stage pin synchronizer, the control register at 0xC0 and vectors starting at 0x0003 in steps of 8 with one slot skipped after the serial source. Together these give the full vector set, the exact synchronizer latency for edge and level detection, and both register write paths. A behavioural model predicts the request, vector, clear pulses and readback every cycle. Directed sequences reach nested preemption, the return-order rule and acknowledges that arrive with no request outstanding.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int NUM_SRC = 7;
  localparam int NUM_EXT = 4;
  localparam int IDX_W   = $clog2(NUM_SRC);

  localparam logic [IDX_W-1:0] SLOT_TMR0 = IDX_W'(1);
  localparam logic [IDX_W-1:0] SLOT_TMR1 = IDX_W'(3);

  typedef struct packed {
    logic             take;
    logic [IDX_W-1:0] srcSel;
  } ackStrobe_t;

  // polling slot of each external pin
  function automatic logic [IDX_W-1:0] extSlot(input int pin);
    case (pin)
      0:       return IDX_W'(0);
      1:       return IDX_W'(2);
      2:       return IDX_W'(5);
      default: return IDX_W'(6);
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] firstSet(input logic [NUM_SRC-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_src_path.sv
module irq_src_path
  import irq_prio_pkg::*;
#(
  parameter int          SYNC_DEPTH = 2,
  parameter logic [7:0]  CTRL_ADDR  = 8'hC0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EXT-1:0] extPinN,
  input  logic [1:0]         extEdgeMode,
  input  logic [1:0]         tmrFlag,
  input  logic               serFlag,
  input  logic [4:0]         srcEn,
  input  logic [4:0]         srcHiPrio,
  input  logic               byteWrEn,
  input  logic [7:0]         byteAddr,
  input  logic [7:0]         byteData,
  input  logic               bitWrEn,
  input  logic [7:0]         bitAddr,
  input  logic               bitData,
  input  ackStrobe_t         strb,
  output logic [NUM_SRC-1:0] pend,
  output logic [NUM_SRC-1:0] enable,
  output logic [NUM_SRC-1:0] hiPrio,
  output logic [7:0]         ctrlRdData
);
  logic [NUM_EXT-1:0] syncQ [SYNC_DEPTH];
  logic [NUM_EXT-1:0] prevQ, held, heldNext, synced, fallSeen;
  logic [NUM_EXT-1:0] mode, extPend, clrExt, touch, swVal, base;
  logic [5:0]         ctrlKeep;   // {PX3,EX3,IT3,PX2,EX2,IT2}
  logic [7:0]         ctrlNext, ctrlNow;
  logic               byteHit, bitHit;

  assign byteHit = byteWrEn && (byteAddr == CTRL_ADDR);
  assign bitHit  = bitWrEn && (bitAddr[7:3] == CTRL_ADDR[7:3]);

  assign ctrlNow = {ctrlKeep[5:4], 1'b0, ctrlKeep[3:1], 1'b0, ctrlKeep[0]};

  always_comb begin
    ctrlNext = ctrlNow;
    if (byteHit) ctrlNext = byteData;
    if (bitHit)  ctrlNext[bitAddr[2:0]] = bitData;
  end

  assign touch = {byteHit || (bitHit && bitAddr[2:0] == 3'd5),
                  byteHit || (bitHit && bitAddr[2:0] == 3'd1), 2'b00};
  assign swVal = {ctrlNext[5], ctrlNext[1], 2'b00};

  assign mode     = {ctrlKeep[3], ctrlKeep[0], extEdgeMode};
  assign synced   = syncQ[SYNC_DEPTH-1];
  assign fallSeen = prevQ & ~synced;

  generate
    for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext
      assign clrExt[g]   = strb.take && (strb.srcSel == extSlot(g));
      assign base[g]     = touch[g] ? swVal[g] : held[g];
      assign heldNext[g] = mode[g] && ((base[g] && !clrExt[g]) || fallSeen[g]);
      assign extPend[g]  = mode[g] ? held[g] : !synced[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < SYNC_DEPTH; k++) syncQ[k] <= '1;
      prevQ    <= '1;
      held     <= '0;
      ctrlKeep <= '0;
    end else begin
      syncQ[0] <= extPinN;
      for (int k = 1; k < SYNC_DEPTH; k++) syncQ[k] <= syncQ[k-1];
      prevQ    <= synced;
      held     <= heldNext;
      ctrlKeep <= {ctrlNext[7:6], ctrlNext[4:2], ctrlNext[0]};
    end
  end

  assign pend   = {extPend[3], extPend[2], serFlag, tmrFlag[1], extPend[1], tmrFlag[0], extPend[0]};
  assign enable = {ctrlKeep[4], ctrlKeep[1], srcEn};
  assign hiPrio = {ctrlKeep[5], ctrlKeep[2], srcHiPrio};
  assign ctrlRdData = {ctrlKeep[5:4], extPend[3], ctrlKeep[3:1], extPend[2], ctrlKeep[0]};

  AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (($past(fallSeen & mode) & ~held) == '0)); // R3
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_prio_pkg::*;
#(
  parameter int          VEC_W    = 16,
  parameter logic [15:0] VEC_BASE = 16'h0003,
  parameter int          VEC_STEP = 8,
  parameter int          GAP_SLOT = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] enable,
  input  logic [NUM_SRC-1:0] hiPrio,
  input  logic               globalEn,
  input  logic               irqAck,
  input  logic               irqRet,
  output ackStrobe_t         strb,
  output logic               irqReq,
  output logic [VEC_W-1:0]   irqVector,
  output logic [1:0]         timerClr
);
  logic [NUM_SRC-1:0] elig, hiCand, loCand;
  logic               nxtValid, nxtHi, reqQ, selHiQ, inSvcHi, inSvcLo, ackTake;
  logic [IDX_W-1:0]   nxtIdx, selQ;
  int                 slotPos;

  assign elig   = pend & enable & {NUM_SRC{globalEn}};
  assign hiCand = elig & hiPrio;
  assign loCand = elig & ~hiPrio;

  always_comb begin
    nxtValid = 1'b0;
    nxtHi    = 1'b0;
    nxtIdx   = '0;
    if (!inSvcHi) begin
      if (|hiCand) begin
        nxtValid = 1'b1;
        nxtHi    = 1'b1;
        nxtIdx   = firstSet(hiCand);
      end else if (!inSvcLo && |loCand) begin
        nxtValid = 1'b1;
        nxtIdx   = firstSet(loCand);
      end
    end
  end

  assign ackTake = irqAck && reqQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ    <= 1'b0;
      selQ    <= '0;
      selHiQ  <= 1'b0;
      inSvcHi <= 1'b0;
      inSvcLo <= 1'b0;
    end else begin
      reqQ   <= ackTake ? 1'b0 : nxtValid;
      selQ   <= nxtIdx;
      selHiQ <= nxtHi;
      if (ackTake) begin
        if (selHiQ) inSvcHi <= 1'b1;
        else        inSvcLo <= 1'b1;
      end else if (irqRet) begin
        if (inSvcHi) inSvcHi <= 1'b0;
        else         inSvcLo <= 1'b0;
      end
    end
  end

  assign strb.take   = ackTake;
  assign strb.srcSel = selQ;
  assign timerClr    = {ackTake && selQ == SLOT_TMR1, ackTake && selQ == SLOT_TMR0};
  assign irqReq      = reqQ;

  assign slotPos   = (int'(selQ) < GAP_SLOT) ? int'(selQ) : int'(selQ) + 1;
  assign irqVector = VEC_W'(VEC_BASE) + VEC_W'(slotPos * VEC_STEP);

  AST_HI_NO_NEST: assert property (@(posedge clk) disable iff (!rstN)
    $past(inSvcHi) |-> !irqReq); // R9
  AST_LO_ONLY_HI: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inSvcLo) && irqReq) |-> selHiQ); // R9
  AST_RET_POP_HI: assert property (@(posedge clk) disable iff (!rstN)
    $past(irqRet && inSvcHi && !ackTake) |-> !inSvcHi); // R9
  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(globalEn) |-> !irqReq); // R8
  AST_TCLR_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (timerClr != 2'b00) |-> (irqReq && irqAck)); // R10
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int          SYNC_DEPTH = 2,
  parameter logic [7:0]  CTRL_ADDR  = 8'hC0,
  parameter int          VEC_W      = 16,
  parameter logic [15:0] VEC_BASE   = 16'h0003,
  parameter int          VEC_STEP   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       extPinN,
  input  logic [1:0]       extEdgeMode,
  input  logic [1:0]       tmrFlag,
  input  logic             serFlag,
  input  logic [4:0]       srcEn,
  input  logic [4:0]       srcHiPrio,
  input  logic             globalEn,
  input  logic             byteWrEn,
  input  logic [7:0]       byteAddr,
  input  logic [7:0]       byteData,
  input  logic             bitWrEn,
  input  logic [7:0]       bitAddr,
  input  logic             bitData,
  output logic [7:0]       ctrlRdData,
  input  logic             irqAck,
  input  logic             irqRet,
  output logic             irqReq,
  output logic [VEC_W-1:0] irqVector,
  output logic [1:0]       timerClr
);
  ackStrobe_t         strb;
  logic [NUM_SRC-1:0] pend, enable, hiPrio;

  irq_src_path #(.SYNC_DEPTH(SYNC_DEPTH), .CTRL_ADDR(CTRL_ADDR)) u_path (
    .clk(clk), .rstN(rstN), .extPinN(extPinN), .extEdgeMode(extEdgeMode),
    .tmrFlag(tmrFlag), .serFlag(serFlag), .srcEn(srcEn), .srcHiPrio(srcHiPrio),
    .byteWrEn(byteWrEn), .byteAddr(byteAddr), .byteData(byteData),
    .bitWrEn(bitWrEn), .bitAddr(bitAddr), .bitData(bitData), .strb(strb),
    .pend(pend), .enable(enable), .hiPrio(hiPrio), .ctrlRdData(ctrlRdData));

  irq_arbiter #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_arb (
    .clk(clk), .rstN(rstN), .pend(pend), .enable(enable), .hiPrio(hiPrio),
    .globalEn(globalEn), .irqAck(irqAck), .irqRet(irqRet), .strb(strb),
    .irqReq(irqReq), .irqVector(irqVector), .timerClr(timerClr));
endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  logic clk = 0, rstN = 0;
  logic [3:0] extPinN = 4'hF;
  logic [1:0] extEdgeMode = 0, tmrFlag = 0, timerClr;
  logic serFlag = 0, globalEn = 0, byteWrEn = 0, bitWrEn = 0, bitData = 0;
  logic irqAck = 0, irqRet = 0, irqReq;
  logic [4:0] srcEn = 0, srcHiPrio = 0;
  logic [7:0] byteAddr = 0, byteData = 0, bitAddr = 0, ctrlRdData;
  logic [15:0] irqVector;
  int testCount = 0, failCount = 0;
  bit running = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  irq_prio_ctrl uut (.*);

  // peripheral model: timer flags drop when cleared
  always @(posedge clk) begin
    if (timerClr[0]) tmrFlag[0] <= 1'b0;
    if (timerClr[1]) tmrFlag[1] <= 1'b0;
  end

  // behavioural reference model
  logic [3:0] m1, m2, m3, mHeld, md, ep, tch, nh;
  logic [7:0] mCtrl, nCtrl;
  logic mReq, mHi, mSvcHi, mSvcLo, take, nV, nH, bse, clr;
  int mSel, nI, hiI, loI;
  bit mp[7], me[7], mpr[7];
  int vecTab[7] = '{3, 11, 19, 27, 35, 51, 59};
  int slotOf[4] = '{0, 2, 5, 6};

  function automatic logic [3:0] curMode();
    return {mCtrl[4], mCtrl[0], extEdgeMode};
  endfunction
  function automatic logic [3:0] curPend();
    logic [3:0] md2, r;
    md2 = curMode();
    for (int k = 0; k < 4; k++) r[k] = md2[k] ? mHeld[k] : !m2[k];
    return r;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      m1 = 4'hF; m2 = 4'hF; m3 = 4'hF; mHeld = 0; mCtrl = 0;
      mReq = 0; mSel = 0; mHi = 0; mSvcHi = 0; mSvcLo = 0;
    end else begin
      md = curMode(); ep = curPend();
      mp = '{ep[0], tmrFlag[0], ep[1], tmrFlag[1], serFlag, ep[2], ep[3]};
      me = '{srcEn[0], srcEn[1], srcEn[2], srcEn[3], srcEn[4], mCtrl[2], mCtrl[6]};
      mpr = '{srcHiPrio[0], srcHiPrio[1], srcHiPrio[2], srcHiPrio[3], srcHiPrio[4], mCtrl[3], mCtrl[7]};
      hiI = -1; loI = -1;
      for (int s = 0; s < 7; s++) begin
        if (mp[s] && me[s] && globalEn) begin
          if (mpr[s] && hiI < 0) hiI = s;
          if (!mpr[s] && loI < 0) loI = s;
        end
      end
      nV = 0; nH = 0; nI = 0;
      if (!mSvcHi) begin
        if (hiI >= 0) begin nV = 1; nH = 1; nI = hiI; end
        else if (!mSvcLo && loI >= 0) begin nV = 1; nI = loI; end
      end
      take = irqAck && mReq;
      nCtrl = mCtrl; tch = 0;
      if (byteWrEn && byteAddr == 8'hC0) begin nCtrl = byteData; tch = 4'b1100; end
      if (bitWrEn && bitAddr[7:3] == 5'b11000) begin
        nCtrl[bitAddr[2:0]] = bitData;
        if (bitAddr[2:0] == 3'd1) tch[2] = 1;
        if (bitAddr[2:0] == 3'd5) tch[3] = 1;
      end
      for (int k = 0; k < 4; k++) begin
        bse = tch[k] ? (k == 2 ? nCtrl[1] : nCtrl[5]) : mHeld[k];
        clr = take && (mSel == slotOf[k]);
        nh[k] = md[k] && ((bse && !clr) || (m3[k] && !m2[k]));
      end
      if (take) begin
        if (mHi) mSvcHi = 1; else mSvcLo = 1;
      end else if (irqRet) begin
        if (mSvcHi) mSvcHi = 0; else mSvcLo = 0;
      end
      mReq = take ? 1'b0 : nV; mSel = nI; mHi = nH;
      mHeld = nh; mCtrl = nCtrl; m3 = m2; m2 = m1; m1 = extPinN;
    end
  end

  task automatic chk(string tag, int act, int exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle compare, just before each rising edge
  always @(negedge clk) begin
    logic [3:0] p;
    logic [7:0] expRd;
    logic [1:0] expClr;
    #4;
    if (rstN && running) begin
      p = curPend();
      expRd = {mCtrl[7:6], p[3], mCtrl[4:2], p[2], mCtrl[0]};
      expClr = {irqAck && mReq && mSel == 3, irqAck && mReq && mSel == 1};
      chk({phase, " irqReq"}, int'(irqReq), int'(mReq));
      if (mReq) chk({phase, " irqVector"}, int'(irqVector), vecTab[mSel]);
      chk({phase, " timerClr"}, int'(timerClr), int'(expClr));
      chk({phase, " ctrlRdData"}, int'(ctrlRdData), int'(expRd));
    end
  end

  task automatic drv(); @(negedge clk); #1; endtask
  task automatic settle(int n);
    repeat (n) @(posedge clk);
    @(negedge clk); #4;
  endtask
  task automatic byteWr(logic [7:0] a, logic [7:0] d);
    drv(); byteWrEn = 1; byteAddr = a; byteData = d;
    drv(); byteWrEn = 0;
  endtask
  task automatic bitWr(logic [7:0] a, logic v);
    drv(); bitWrEn = 1; bitAddr = a; bitData = v;
    drv(); bitWrEn = 0;
  endtask
  task automatic doAck(string tag, logic [1:0] expClr);
    drv(); irqAck = 1; #3;
    chk(tag, int'(timerClr), int'(expClr));
    drv(); irqAck = 0;
  endtask
  task automatic doRet();
    drv(); irqRet = 1;
    drv(); irqRet = 0;
  endtask

  initial begin
    #2_000_000;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    drv(); rstN = 1; running = 1;
    settle(1);
    chk("R1 reset irqReq", int'(irqReq), 0);
    chk("R1 reset timerClr", int'(timerClr), 0);
    chk("R1 reset ctrlRdData", int'(ctrlRdData), 0);

    phase = "R2";
    byteWr(8'hC1, 8'hFF); settle(1);
    chk("R2 wrong byte addr ignored", int'(ctrlRdData), 0);
    byteWr(8'hC0, 8'h44); settle(1);
    chk("R2 byte write", int'(ctrlRdData), 8'h44);
    bitWr(8'hC0, 1); settle(1);
    chk("R2 bit write IT2", int'(ctrlRdData), 8'h45);
    bitWr(8'hCC, 1); settle(1);
    chk("R2 bit addr outside ignored", int'(ctrlRdData), 8'h45);
    bitWr(8'hC4, 1); settle(1);
    chk("R2 bit write IT3", int'(ctrlRdData), 8'h55);

    phase = "R3";
    globalEn = 1;
    drv(); extPinN[2] = 0;
    drv(); extPinN[2] = 1;
    settle(6);
    chk("R3 edge held after pin high", int'(ctrlRdData), 8'h57);
    chk("R5 ext2 vector", int'(irqVector), 16'h0033);
    doAck("R3 ack no timer clr", 2'b00);
    settle(1);
    chk("R3 pending cleared on ack", int'(ctrlRdData), 8'h55);
    doRet();

    phase = "R4";
    bitWr(8'hC4, 0);
    drv(); extPinN[3] = 0;
    settle(5);
    chk("R4 level request", int'(irqReq), 1);
    chk("R5 ext3 vector", int'(irqVector), 16'h003B);
    drv(); extPinN[3] = 1;
    settle(5);
    chk("R4 level released", int'(irqReq), 0);

    phase = "R6";
    drv(); srcEn = 5'h1F; tmrFlag = 2'b11; serFlag = 1; extPinN[1] = 0;
    settle(4);
    chk("R6 timer0 first", int'(irqVector), 16'h000B);
    doAck("R10 timer0 clear", 2'b01); doRet(); settle(3);
    chk("R6 ext1 next", int'(irqVector), 16'h0013);
    doAck("R10 ext1 no clear", 2'b00);
    drv(); extPinN[1] = 1;
    doRet(); settle(3);
    chk("R6 timer1 next", int'(irqVector), 16'h001B);
    doAck("R10 timer1 clear", 2'b10); doRet(); settle(3);
    chk("R5 serial vector", int'(irqVector), 16'h0023);
    phase = "R10";
    doAck("R10 serial no clear", 2'b00); doRet(); settle(3);
    chk("R10 serial flag persists", int'(irqReq), 1);
    drv(); serFlag = 0;
    settle(3);

    phase = "R7";
    drv(); tmrFlag[0] = 1; serFlag = 1; srcHiPrio = 5'b10000;
    settle(4);
    chk("R7 high serial beats timer0", int'(irqVector), 16'h0023);
    doAck("R7 ack serial", 2'b00);
    drv(); serFlag = 0;
    doRet(); settle(3);
    chk("R7 timer0 after", int'(irqVector), 16'h000B);
    doAck("R7 ack timer0", 2'b01); doRet();

    phase = "R9";
    drv(); srcHiPrio = 0; tmrFlag[1] = 1;
    settle(4);
    doAck("R9 low in service", 2'b10);
    drv(); serFlag = 1;
    settle(4);
    chk("R9 low cannot preempt low", int'(irqReq), 0);
    drv(); srcHiPrio = 5'b10000;
    settle(3);
    chk("R9 high preempts low", int'(irqVector), 16'h0023);
    doAck("R9 ack high", 2'b00);
    drv(); tmrFlag[0] = 1; srcHiPrio = 5'b10010; serFlag = 0;
    settle(4);
    chk("R9 high blocks all", int'(irqReq), 0);
    doRet(); settle(3);
    chk("R9 return pops high only", int'(irqVector), 16'h000B);
    doAck("R9 ack hi timer0", 2'b01);
    drv(); srcHiPrio = 0; extPinN[3] = 0;
    doRet(); settle(4);
    chk("R9 low still in service", int'(irqReq), 0);
    doRet(); settle(3);
    chk("R9 second return frees low", int'(irqVector), 16'h003B);
    doAck("R9 ack ext3", 2'b00);
    drv(); extPinN[3] = 1;
    doRet(); settle(4);

    phase = "R8";
    drv(); srcEn = 0; tmrFlag[0] = 1;
    settle(4);
    chk("R8 source enable off", int'(irqReq), 0);
    drv(); srcEn = 5'h1F; globalEn = 0;
    settle(4);
    chk("R8 global enable off", int'(irqReq), 0);
    drv(); globalEn = 1;
    settle(3);
    chk("R8 enabled again", int'(irqVector), 16'h000B);
    doAck("R8 ack", 2'b01); doRet(); settle(3);

    phase = "R11";
    bitWr(8'hC2, 0); bitWr(8'hC0, 1);
    drv(); extPinN[2] = 0;
    drv(); extPinN[2] = 1;
    settle(6);
    chk("R11 ext2 pending but disabled", int'(ctrlRdData), 8'h43);
    chk("R11 no request", int'(irqReq), 0);
    doAck("R11 stray ack", 2'b00);
    settle(2);
    chk("R11 stray ack keeps pending", int'(ctrlRdData), 8'h43);
    bitWr(8'hC1, 0); settle(1);
    chk("R2 software clears pending", int'(ctrlRdData), 8'h41);

    settle(2);
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule